// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block is the control unit of a small single-bus 16-bit accumulator machine. It holds a read-only control store of horizontal microwords and a micro-address register. Each microword carries 28 control bits, one per datapath action with no field decoding, and a 6-bit next-address field in its low bits. The control bits go directly to the datapath. The sequencer then moves to the successor that the word names.

One next-address value, all ones, is a dispatch request. When a word carries that value, the sequencer does not follow the field. It forms an entry address from the prefix `2'b11` and the 4-bit opcode of the current instruction. Every instruction starts with a shared three-word fetch routine at address 0, whose last word dispatches. The entry word for each opcode then jumps to that opcode's routine. The final word of each routine returns to address 0.

The control output is registered. It always shows the control field of the word at the current micro-address.

Top module: `useq_ctrl`

## Requirements
- R1: While reset (active low) is asserted, and on release, the micro-address is 0 and the control output is 28'h0000003.
- R2: The fetch routine runs through addresses 0, 1, 2 with control values 28'h0000003, 28'h400000C and 28'h0000060.
- R3: The word at address 2 requests dispatch. The next address is {2'b11, opcode}, with the opcode sampled on that edge only. Opcode changes in any other cycle have no effect.
- R4: The entry words at addresses 48 to 53 (opcodes 0 to 5) have control 28'h0000082. Each is followed by the first word of its opcode's routine.
- R5: The routine for opcode k (0 to 5) starts at address 3 + k(k+3)/2, is k+2 words long, and is walked in ascending address order.
- R6: In a routine, the first non-final word has control 28'h4000008 (bits 3 and 26). Every later non-final word has 28'h0400020 (bits 5 and 22).
- R7: The final word of routine k sets bit 27. For k=0 it also sets bits 9 and 10. For k=1..5 it also sets bit 25 and bit 10+k. It is followed by address 0.
- R8: Addresses 54 to 63 (opcodes 6 to 15) are outside the store. They give a zero control word and are followed by address 0.
- R9: The control output changes on the same edge as the micro-address and always equals the control field of the word at that address.
- R10: Asserting reset in the middle of a routine returns the micro-address to 0 at once, with the fetch control value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 4 | Opcode field of the current instruction |
| ctl_word | output | 28 | Registered control bits to the datapath |
| uaddr | output | 6 | Current micro-address |

## Verification
The difficult case is showing that the opcode matters on exactly one edge of each instruction. Outside that edge the input has to be noisy and still be ignored. The driver puts the inverted opcode on the input during the first two fetch words. It switches to the real opcode only while the dispatch word is current. Right after the dispatch edge it changes the opcode to another value. A wrong sampling point therefore sends the trace to a different entry. Every opcode value, including those that leave the store, is run through the full expected address and control trace. A reset is also forced in the middle of the longest routine.

// File: rtl/useq_ctrl.sv
`timescale 1ns/1ps
module useq_ctrl #(
  parameter int OPC_W = 4,
  parameter int AW    = 6,
  parameter int CTL_W = 28,
  parameter int DEPTH = 54,
  parameter int NROUT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  output logic [CTL_W-1:0] ctl_word,
  output logic [AW-1:0]    uaddr
);
  localparam int MW      = CTL_W + AW;
  localparam int PFX_W   = AW - OPC_W;
  localparam int ENTRY0  = ((1 << PFX_W) - 1) << OPC_W;
  localparam int FETCH_N = 3;
  localparam logic [AW-1:0] DISPATCH = '1;
  localparam logic [CTL_W-1:0] ONE = 1;

  localparam int B_PC_BUS  = 0;
  localparam int B_MAR_LD  = 1;
  localparam int B_PC_INC  = 2;
  localparam int B_MEM_RD  = 3;
  localparam int B_MDR_BUS = 5;
  localparam int B_IR_LD   = 6;
  localparam int B_IRF_BUS = 7;
  localparam int B_ACC_BUS = 9;
  localparam int B_MDR_LD  = 10;
  localparam int B_ALU0    = 10;
  localparam int B_OPB_LD  = 22;
  localparam int B_ALU_ACC = 25;
  localparam int B_MEM_SEL = 26;
  localparam int B_END     = 27;

  function automatic int rbase(input int k);
    return FETCH_N + (k * (k + 3)) / 2;
  endfunction

  function automatic logic [MW-1:0] word_at(input int a);
    logic [CTL_W-1:0] c;
    int nxt;
    c   = '0;
    nxt = 0;
    if (a == 0) begin
      c = (ONE << B_PC_BUS) | (ONE << B_MAR_LD);
      nxt = 1;
    end else if (a == 1) begin
      c = (ONE << B_PC_INC) | (ONE << B_MEM_RD) | (ONE << B_MEM_SEL);
      nxt = 2;
    end else if (a == 2) begin
      c = (ONE << B_MDR_BUS) | (ONE << B_IR_LD);
      nxt = int'(DISPATCH);
    end else if (a >= ENTRY0 && a < ENTRY0 + NROUT) begin
      c = (ONE << B_IRF_BUS) | (ONE << B_MAR_LD);
      nxt = rbase(a - ENTRY0);
    end else begin
      for (int k = 0; k < NROUT; k++) begin
        if (a >= rbase(k) && a < rbase(k) + k + 2) begin
          if (a == rbase(k) + k + 1) begin
            c = ONE << B_END;
            if (k == 0) c = c | (ONE << B_ACC_BUS) | (ONE << B_MDR_LD);
            else        c = c | (ONE << B_ALU_ACC) | (ONE << (B_ALU0 + k));
            nxt = 0;
          end else if (a == rbase(k)) begin
            c = (ONE << B_MEM_RD) | (ONE << B_MEM_SEL);
            nxt = a + 1;
          end else begin
            c = (ONE << B_MDR_BUS) | (ONE << B_OPB_LD);
            nxt = a + 1;
          end
        end
      end
    end
    return {c, AW'(nxt)};
  endfunction

  logic [CTL_W-1:0] rom_ctl [DEPTH];
  logic [AW-1:0]    rom_nxt [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_store
    logic [MW-1:0] w;
    assign w          = word_at(g);
    assign rom_ctl[g] = w[MW-1:AW];
    assign rom_nxt[g] = w[AW-1:0];
  end

  logic [AW-1:0]    uaddr_q, nxt, rd_next;
  logic [CTL_W-1:0] ctl_q, nxt_ctl;
  logic             cur_in, nxt_in;

  assign cur_in  = uaddr_q < AW'(DEPTH);
  assign rd_next = cur_in ? rom_nxt[uaddr_q] : '0;
  assign nxt     = (rd_next == DISPATCH) ? {{PFX_W{1'b1}}, opcode} : rd_next;
  assign nxt_in  = nxt < AW'(DEPTH);
  assign nxt_ctl = nxt_in ? rom_ctl[nxt] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uaddr_q <= '0;
      ctl_q   <= rom_ctl[0];
    end else begin
      uaddr_q <= nxt;
      ctl_q   <= nxt_ctl;
    end
  end

  assign uaddr    = uaddr_q;
  assign ctl_word = ctl_q;

  AST_RESET_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (uaddr_q == '0)); // R1
  AST_SEQ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_next != DISPATCH) |=> (uaddr_q == $past(rd_next))); // R5
  AST_DISPATCH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_next == DISPATCH) |=> (uaddr_q[OPC_W-1:0] == $past(opcode)) && (&uaddr_q[AW-1:OPC_W])); // R3
  AST_CTL_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    cur_in |-> (ctl_q == rom_ctl[uaddr_q])); // R9
  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_in |-> (ctl_q == '0)); // R8
  AST_OOR_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_in |=> (uaddr_q == '0)); // R8
  AST_END_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[B_END] |=> (uaddr_q == '0)); // R7
endmodule

// File: tb/tb_useq_ctrl.sv
`timescale 1ns/1ps
module tb_useq_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  opcode = 0;
  logic [27:0] ctl_word;
  logic [5:0]  uaddr;

  useq_ctrl dut (.clk(clk), .rst_n(rst_n), .opcode(opcode), .ctl_word(ctl_word), .uaddr(uaddr));

  always #10 clk = ~clk;

  typedef struct { logic [5:0] a; logic [27:0] c; string req; } exp_t;
  exp_t q[$];
  int total = 0, bad = 0;
  bit mon_en = 0, done = 0;

  localparam logic [27:0] C_F0 = 28'h0000003, C_F1 = 28'h400000C, C_F2 = 28'h0000060;
  localparam logic [27:0] C_ENT = 28'h0000082, C_S0 = 28'h4000008, C_SN = 28'h0400020;

  task automatic push(input int a, input logic [27:0] c, input string req);
    exp_t e;
    e.a = 6'(a); e.c = c; e.req = req;
    q.push_back(e);
  endtask

  task automatic chk(input bit ok, input string req, input int aa, input logic [27:0] ac,
                     input int ea, input logic [27:0] ec);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: addr=%0d ctl=%h expected addr=%0d ctl=%h", req, aa, ac, ea, ec);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (q.size() == 0) chk(0, "R9 unexpected cycle", uaddr, ctl_word, -1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(uaddr === e.a && ctl_word === e.c, e.req, uaddr, ctl_word, e.a, e.c);
      end
    end
  end

  task automatic run_instr(input int k);
    int n;
    push(0, C_F0, "R2 fetch0");
    push(1, C_F1, "R2 fetch1");
    push(2, C_F2, "R2 fetch2");
    if (k < 6) begin
      int base;
      push(48 + k, C_ENT, "R3 R4 entry");
      base = 3 + (k * (k + 3)) / 2;
      for (int s = 0; s < k + 2; s++) begin
        if (s == k + 1) begin
          logic [27:0] f;
          f = 28'h8000000;
          if (k == 0) f = f | 28'h0000600;
          else f = f | 28'h2000000 | (28'h1 << (10 + k));
          push(base + s, f, "R7 final");
        end else if (s == 0) push(base + s, C_S0, "R5 R6 first step");
        else push(base + s, C_SN, "R5 R6 later step");
      end
      n = 4 + k + 2;
    end else begin
      push(48 + k, 28'h0, "R8 out of range");
      n = 4;
    end
    opcode = ~4'(k);
    @(posedge clk); #2;
    @(posedge clk); #2;
    opcode = 4'(k);
    @(posedge clk); #2;
    opcode = 4'(k) ^ 4'h5;
    repeat (n - 3) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(uaddr === 6'd0 && ctl_word === C_F0, "R1 in reset", uaddr, ctl_word, 0, C_F0);
    @(posedge clk); #2;
    rst_n = 1;
    mon_en = 1;
    for (int k = 0; k < 16; k++) run_instr(k);
    run_instr(5); run_instr(0); run_instr(3); run_instr(15); run_instr(1);
    mon_en = 0;
    opcode = 4'd5;
    repeat (6) @(posedge clk);
    #2;
    rst_n = 0;
    @(negedge clk);
    chk(uaddr === 6'd0 && ctl_word === C_F0, "R10 mid-routine reset", uaddr, ctl_word, 0, C_F0);
    @(posedge clk); #2;
    rst_n = 1;
    mon_en = 1;
    run_instr(2);
    run_instr(4);
    @(negedge clk);
    mon_en = 0;
    chk(uaddr === 6'd0 && ctl_word === C_F0, "R7 return to fetch", uaddr, ctl_word, 0, C_F0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R9 watchdog: addr=%0d ctl=%h expected addr=0 ctl=%h", uaddr, ctl_word, C_F0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule